// File: doc/BRIEF.md
# Page Table Refill Walker

This block refills a translation cache after a miss. The virtual address space is 18 bits wide and is split into 1024-word pages. When the cache misses, the walker takes the faulting virtual address, a user/exec mode flag and a write flag. It then picks one of four table base registers. The choice depends on the mode and on which half of the address space the address falls in. From that base it forms the physical address of the 36-bit table word that holds the entry.

The walker reads the table word and writes it back as one locked read-then-write cycle on the memory port, so no other master can slip in between. Each table word holds two 18-bit entries, and address bit 10 chooses between them. Before the write-back, the walker clears the bits named by one of two programmable 36-bit masks. The mask used depends on which half holds the entry, and software normally sets it to cover the age field. The entry taken from the written-back word is then passed on with its 23-bit physical address. That address is the entry's 13-bit page frame joined to the 10-bit word offset.

Software loads the four bases and the two masks through a small register write port. Each table is a fixed 64 words, and any length field written with a base is dropped.

Top module: `ptw_refill`

## Requirements
- R1: The base is picked by mode and va[17] using these `cfg_sel` codes: user with va[17]=0 uses code 0, user with va[17]=1 uses code 1, exec with va[17]=1 uses code 2, and exec with va[17]=0 uses code 3.
- R2: The table word address `mem_addr` is the 23-bit selected base plus va[16:11], taken modulo 2^23. Only bits [22:0] of `cfg_wdata` are kept when a base is written, so any length field above them has no effect.
- R3: On the cycle after a miss is accepted in idle, `mem_req`=1 with `mem_we`=0. `mem_req`, `mem_we` and `mem_addr` then stay unchanged until `mem_ack`.
- R4: After the read is acknowledged, a write to the same address follows on the next cycle. Its data is the read word AND NOT mask, where the mask is the one written with `cfg_sel` code 4 when va[10]=0 and code 5 when va[10]=1. `mem_lock` is high whenever `mem_req` is high, from the start of the read until the write is acknowledged.
- R5: va[10]=0 selects bits [35:18] of the written-back word as the entry, and va[10]=1 selects bits [17:0].
- R6: `ent_valid` pulses for exactly one cycle, on the cycle after the write acknowledge. In that cycle `ent_pa` = {entry[12:0], va[9:0]}, and `ent_user` and `ent_write` repeat the flags given with the miss.
- R7: `busy` is high from the cycle after acceptance through the `ent_valid` cycle, and low on the cycle after that.
- R8: A miss presented while `busy` is high is ignored and starts no memory access.
- R9: After reset, `busy`, `mem_req`, `mem_lock` and `ent_valid` are low, and all bases and masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request |
| miss_va | input | 18 | Faulting virtual address |
| miss_user | input | 1 | 1 = user mode, 0 = exec mode |
| miss_write | input | 1 | Faulting reference was a write |
| busy | output | 1 | Walk in progress |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0-3 bases, 4 left-half mask, 5 right-half mask |
| cfg_wdata | input | 36 | Configuration write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_lock | output | 1 | Bus lock across read and write-back |
| mem_addr | output | 23 | Physical table word address |
| mem_wdata | output | 36 | Write-back data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 36 | Read data, valid with ack in read phase |
| ent_valid | output | 1 | Entry delivery strobe |
| ent_entry | output | 18 | Selected table entry |
| ent_pa | output | 23 | Physical address {page frame, offset} |
| ent_user | output | 1 | Mode of the delivered walk |
| ent_write | output | 1 | Write flag of the delivered walk |

## Verification
The bench uses the default parameters: an 18-bit virtual address, a 10-bit offset, a 36-bit word and 23-bit bases. With these values the table index is 6 bits wide, so placing a base near 2^23 makes the address wrap. Random 36-bit table words and random masks exercise both halfwords under both mask registers. Random acknowledge delays of zero to three cycles check that the request and lock stay stable while the walker waits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

    localparam int unsigned NUM_BASES = 4;
    localparam int unsigned CFG_SEL_W = 3;

    localparam logic [CFG_SEL_W-1:0] SEL_USER_LO = 3'd0;
    localparam logic [CFG_SEL_W-1:0] SEL_USER_HI = 3'd1;
    localparam logic [CFG_SEL_W-1:0] SEL_EXEC_HI = 3'd2;
    localparam logic [CFG_SEL_W-1:0] SEL_EXEC_LO = 3'd3;
    localparam logic [CFG_SEL_W-1:0] SEL_MASK_L  = 3'd4;
    localparam logic [CFG_SEL_W-1:0] SEL_MASK_R  = 3'd5;

    // Maps mode and address half onto a base register slot.
    function automatic logic [1:0] base_index(input logic user, input logic hi_half);
        logic [CFG_SEL_W-1:0] sel;
        if (user) sel = hi_half ? SEL_USER_HI : SEL_USER_LO;
        else      sel = hi_half ? SEL_EXEC_HI : SEL_EXEC_LO;
        return sel[1:0];
    endfunction

endpackage

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs
    import ptw_pkg::*;
#(
    parameter int unsigned BASE_W = 23,
    parameter int unsigned WORD_W = 36
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [CFG_SEL_W-1:0]                  cfg_sel,
    input  logic [WORD_W-1:0]                     cfg_wdata,
    output logic [NUM_BASES-1:0][BASE_W-1:0]      bases_o,
    output logic [WORD_W-1:0]                     mask_l_o,
    output logic [WORD_W-1:0]                     mask_r_o
);

    logic [NUM_BASES-1:0][BASE_W-1:0] base_d, base_q;
    logic [WORD_W-1:0] mask_l_d, mask_l_q;
    logic [WORD_W-1:0] mask_r_d, mask_r_q;

    for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
        // Only the address bits are kept; a length field above them is dropped.
        always_comb begin
            base_d[g] = base_q[g];
            if (cfg_we && cfg_sel == CFG_SEL_W'(g))
                base_d[g] = cfg_wdata[BASE_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) base_q[g] <= '0;
            else        base_q[g] <= base_d[g];
        end
    end

    always_comb begin
        mask_l_d = mask_l_q;
        mask_r_d = mask_r_q;
        if (cfg_we && cfg_sel == SEL_MASK_L) mask_l_d = cfg_wdata;
        if (cfg_we && cfg_sel == SEL_MASK_R) mask_r_d = cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_l_q <= '0;
            mask_r_q <= '0;
        end else begin
            mask_l_q <= mask_l_d;
            mask_r_q <= mask_r_d;
        end
    end

    assign bases_o  = base_q;
    assign mask_l_o = mask_l_q;
    assign mask_r_o = mask_r_q;

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W   = 18,
    parameter int unsigned OFF_W  = 10,
    parameter int unsigned BASE_W = 23
) (
    input  logic [NUM_BASES-1:0][BASE_W-1:0] bases,
    input  logic                             user,
    input  logic [VA_W-1:0]                  va,
    output logic [BASE_W-1:0]                tbl_addr
);

    // Bit OFF_W picks the halfword and the top bit picks the table,
    // so the word index within a table is what lies between them.
    localparam int unsigned IDX_W = VA_W - OFF_W - 2;
    localparam int unsigned IDX_LO = OFF_W + 1;

    logic [IDX_W-1:0]  word_idx;
    logic [BASE_W-1:0] base_sel;

    always_comb begin
        word_idx = va[IDX_LO +: IDX_W];
        base_sel = bases[base_index(user, va[VA_W-1])];
        tbl_addr = base_sel + BASE_W'(word_idx);
    end

endmodule

// File: rtl/ptw_entry_pick.sv
module ptw_entry_pick #(
    parameter int unsigned WORD_W = 36,
    localparam int unsigned HALF_W = WORD_W / 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] mask_l,
    input  logic [WORD_W-1:0] mask_r,
    input  logic              right_half,
    output logic [WORD_W-1:0] wb_word,
    output logic [HALF_W-1:0] entry
);

    always_comb begin
        wb_word = word & ~(right_half ? mask_r : mask_l);
        entry   = right_half ? wb_word[HALF_W-1:0] : wb_word[WORD_W-1:HALF_W];
    end

endmodule

// File: rtl/ptw_refill.sv
module ptw_refill
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W   = 18,
    parameter int unsigned OFF_W  = 10,
    parameter int unsigned WORD_W = 36,
    parameter int unsigned BASE_W = 23,
    parameter int unsigned PPN_W  = 13,
    localparam int unsigned HALF_W = WORD_W / 2,
    localparam int unsigned PA_W   = PPN_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_valid,
    input  logic [VA_W-1:0]      miss_va,
    input  logic                 miss_user,
    input  logic                 miss_write,
    output logic                 busy,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_lock,
    output logic [BASE_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 ent_valid,
    output logic [HALF_W-1:0]    ent_entry,
    output logic [PA_W-1:0]      ent_pa,
    output logic                 ent_user,
    output logic                 ent_write
);

    typedef struct packed {
        walk_state_e         state;
        logic [VA_W-1:0]     va;
        logic                user;
        logic                wr;
        logic [BASE_W-1:0]   addr;
        logic [WORD_W-1:0]   word;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [NUM_BASES-1:0][BASE_W-1:0] bases;
    logic [WORD_W-1:0] mask_l, mask_r;
    logic [BASE_W-1:0] miss_addr;
    logic [WORD_W-1:0] wb_word;
    logic [HALF_W-1:0] entry;

    ptw_cfg_regs #(
        .BASE_W (BASE_W),
        .WORD_W (WORD_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .bases_o   (bases),
        .mask_l_o  (mask_l),
        .mask_r_o  (mask_r)
    );

    // Address formed from the miss itself so it is fixed for the whole walk.
    ptw_addr_gen #(
        .VA_W   (VA_W),
        .OFF_W  (OFF_W),
        .BASE_W (BASE_W)
    ) u_addr (
        .bases    (bases),
        .user     (miss_user),
        .va       (miss_va),
        .tbl_addr (miss_addr)
    );

    ptw_entry_pick #(
        .WORD_W (WORD_W)
    ) u_pick (
        .word       (walk_q.word),
        .mask_l     (mask_l),
        .mask_r     (mask_r),
        .right_half (walk_q.va[OFF_W]),
        .wb_word    (wb_word),
        .entry      (entry)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (miss_valid) begin
                    walk_d.state = ST_READ;
                    walk_d.va    = miss_va;
                    walk_d.user  = miss_user;
                    walk_d.wr    = miss_write;
                    walk_d.addr  = miss_addr;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    walk_d.word  = mem_rdata;
                    walk_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) walk_d.state = ST_DONE;
            end
            ST_DONE: begin
                walk_d.state = ST_IDLE;
            end
            default: walk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{state: ST_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy      = (walk_q.state != ST_IDLE);
    assign mem_req   = (walk_q.state == ST_READ) || (walk_q.state == ST_WRITE);
    assign mem_we    = (walk_q.state == ST_WRITE);
    assign mem_lock  = mem_req;
    assign mem_addr  = walk_q.addr;
    assign mem_wdata = wb_word;
    assign ent_valid = (walk_q.state == ST_DONE);
    assign ent_entry = entry;
    assign ent_pa    = {entry[PPN_W-1:0], walk_q.va[OFF_W-1:0]};
    assign ent_user  = walk_q.user;
    assign ent_write = walk_q.wr;

endmodule

// File: rtl/ptw_refill_chk.sv
module ptw_refill_chk #(
    parameter int unsigned BASE_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic [BASE_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              ent_valid
);

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy) |=> (busy && mem_req && !mem_we));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    assert_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

    assert_deliver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (ent_valid && !mem_req));

    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |=> !ent_valid);

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> busy);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |=> !busy);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !mem_lock && !ent_valid));

endmodule

bind ptw_refill ptw_refill_chk #(.BASE_W(BASE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_lock   (mem_lock),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .ent_valid  (ent_valid)
);

// File: tb/tb_ptw_refill.sv
module tb_ptw_refill;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic [17:0] miss_va;
    logic        miss_user;
    logic        miss_write;
    logic        busy;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [35:0] cfg_wdata;
    logic        mem_req;
    logic        mem_we;
    logic        mem_lock;
    logic [22:0] mem_addr;
    logic [35:0] mem_wdata;
    logic        mem_ack;
    logic [35:0] mem_rdata;
    logic        ent_valid;
    logic [17:0] ent_entry;
    logic [22:0] ent_pa;
    logic        ent_user;
    logic        ent_write;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [22:0] m_base [4];
    logic [35:0] m_mask_l, m_mask_r;

    always #2 clk = ~clk;

    ptw_refill dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_va    (miss_va),
        .miss_user  (miss_user),
        .miss_write (miss_write),
        .busy       (busy),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_lock   (mem_lock),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .ent_valid  (ent_valid),
        .ent_entry  (ent_entry),
        .ent_pa     (ent_pa),
        .ent_user   (ent_user),
        .ent_write  (ent_write)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_slot(input logic user, input logic [17:0] va);
        if (user) return va[17] ? 1 : 0;
        return va[17] ? 2 : 3;
    endfunction

    function automatic logic [22:0] exp_addr(input logic user, input logic [17:0] va);
        return m_base[exp_slot(user, va)] + 23'(va[16:11]);
    endfunction

    function automatic logic [35:0] exp_wb(input logic [35:0] w, input logic [17:0] va);
        return w & ~(va[10] ? m_mask_r : m_mask_l);
    endfunction

    function automatic logic [17:0] exp_entry(input logic [35:0] w, input logic [17:0] va);
        logic [35:0] wb;
        wb = exp_wb(w, va);
        return va[10] ? wb[17:0] : wb[35:18];
    endfunction

    function automatic logic [35:0] rnd36();
        logic [31:0] a;
        logic [31:0] b;
        a = $urandom();
        b = $urandom();
        return {b[3:0], a};
    endfunction

    task automatic cfg_write(input logic [2:0] sel, input logic [35:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 3'd4) m_base[sel[1:0]] = data[22:0];
        else if (sel == 3'd4) m_mask_l = data;
        else if (sel == 3'd5) m_mask_r = data;
    endtask

    task automatic walk(input logic [17:0] va, input logic user, input logic wr,
                        input logic [35:0] word, input int rd_wait, input int wr_wait,
                        input bit inject);
        logic [22:0] ea;
        logic [17:0] ee;
        ea = exp_addr(user, va);
        ee = exp_entry(word, va);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_va = va;
        miss_user = user;
        miss_write = wr;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(busy && mem_req && !mem_we && mem_lock, "R3", "read phase start",
            {mem_req, mem_we, mem_lock}, 3'b101);
        chk(mem_addr == ea, "R1", "table address from base and index", mem_addr, ea);
        for (int i = 0; i < rd_wait; i++) begin
            if (inject && i == 0) begin
                miss_valid = 1'b1;
                miss_va = ~va;
                miss_user = ~user;
            end
            @(negedge clk);
            miss_valid = 1'b0;
            chk(mem_req && !mem_we && mem_addr == ea, "R3", "request held while waiting",
                mem_addr, ea);
        end
        mem_ack = 1'b1;
        mem_rdata = word;
        @(negedge clk);
        mem_ack = 1'b0;
        mem_rdata = rnd36();
        chk(mem_req && mem_we && mem_lock, "R4", "write phase locked",
            {mem_req, mem_we, mem_lock}, 3'b111);
        chk(mem_addr == ea, "R4", "write-back address", mem_addr, ea);
        chk(mem_wdata == exp_wb(word, va), "R4", "write-back data masked",
            mem_wdata, exp_wb(word, va));
        for (int i = 0; i < wr_wait; i++) begin
            @(negedge clk);
            chk(mem_req && mem_we && mem_lock, "R4", "lock held in write wait",
                {mem_req, mem_we, mem_lock}, 3'b111);
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk(ent_valid && busy && !mem_req, "R6", "entry strobe",
            {ent_valid, busy, mem_req}, 3'b110);
        chk(ent_entry == ee, "R5", "halfword entry", ent_entry, ee);
        chk(ent_pa == {ee[12:0], va[9:0]}, "R6", "physical address", ent_pa,
            {ee[12:0], va[9:0]});
        chk(ent_user == user && ent_write == wr, "R6", "flags echoed",
            {ent_user, ent_write}, {user, wr});
        if (inject) begin
            miss_valid = 1'b1;
            miss_va = va ^ 18'h2A5;
        end
        @(negedge clk);
        miss_valid = 1'b0;
        chk(!ent_valid && !busy, "R7", "idle after delivery", {ent_valid, busy}, 2'b00);
        if (inject) begin
            for (int i = 0; i < 3; i++) begin
                chk(!mem_req && !busy, "R8", "miss while busy ignored",
                    {mem_req, busy}, 2'b00);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        rst_n = 1'b0;
        miss_valid = 1'b0; miss_va = '0; miss_user = 1'b0; miss_write = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        mem_ack = 1'b0; mem_rdata = '0;
        for (int i = 0; i < 4; i++) m_base[i] = '0;
        m_mask_l = '0;
        m_mask_r = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state, and zero bases/masks seen through a walk
        chk(!busy && !mem_req && !mem_lock && !ent_valid, "R9", "reset outputs",
            {busy, mem_req, mem_lock, ent_valid}, 4'b0000);
        walk(18'h3FC00, 1'b0, 1'b0, 36'hABCDE_1234, 0, 0, 0);
        chk(1'b1, "R9", "zero base walk done", 0, 0);

        // R1: four distinct bases, all mode/half combinations
        cfg_write(3'd0, 36'h0001000);
        cfg_write(3'd1, 36'h0002000);
        cfg_write(3'd2, 36'h0003000);
        cfg_write(3'd3, 36'h0004000);
        cfg_write(3'd4, 36'h0E000_0000);
        cfg_write(3'd5, 36'h0000_0E000);
        walk(18'h0A800, 1'b1, 1'b0, 36'hFFFFFFFFF, 1, 0, 0);
        walk(18'h2A800, 1'b1, 1'b1, 36'hFFFFFFFFF, 0, 1, 0);
        walk(18'h2AC00, 1'b0, 1'b0, 36'hFFFFFFFFF, 2, 2, 0);
        walk(18'h0AC00, 1'b0, 1'b1, 36'hFFFFFFFFF, 0, 0, 0);

        // R2: length field above the base is dropped, and the sum wraps
        cfg_write(3'd0, 36'hFFF_7FFFF0);
        chk(m_base[0] == 23'h7FFFF0, "R2", "model base", m_base[0], 23'h7FFFF0);
        walk(18'h1F800, 1'b1, 1'b0, 36'h123456789, 1, 1, 0);

        // R8: misses during a walk and during delivery are ignored
        walk(18'h15555, 1'b0, 1'b1, 36'h9ABCDEF01, 3, 1, 1);

        for (int n = 0; n < 60; n++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[2:0] == 3'd0) cfg_write(3'($urandom_range(0, 5)), rnd36());
            walk(r[29:12], r[3], r[4], rnd36(), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), r[5] ? 1'b1 : 1'b0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule